// File: doc/BRIEF.md
# eFuse auto-read controller

This block lets software fetch words from a read-only fuse array through three 32-bit registers. Software loads a word address into the control register and commits it by setting and then clearing an address-commit bit. It then sets the read-start bit, which raises a busy flag. While busy is high the controller issues one byte request per cycle to the fuse array. After a fixed number of cycles it drops busy and, in that same cycle, loads the fetched word into the read-data register. Software polls busy and then reads the result.

The array holds `ARRAY_BYTES` bytes, 512 by default. The array model sits outside the block and returns a byte combinationally for the byte address the block drives. The word width is a parameter, either 1 byte or 4 bytes, and addresses count in words. The power-down bit and the encryption-enable bit are plain stored controls and are driven straight to pins. Reads are accepted only while power-down is clear and auto-read enable is set. Fuse programming is not provided. The write-side fields of the control register are stored and read back but have no effect.

Top module: `efuse_rd_ctrl`

## Requirements
- R1: After reset the control register (offset 0x04) reads 0x0800_0000, with power-down bit 27 set and every other bit clear. The data register (0x08) and the auxiliary register (0x10) read 0, `fuse_pd_o` is 1 and the controller is idle.
- R2: The word address in control bits 10:0 is committed only when a write clears the address-commit bit 11 while that bit was set. The committed value is the address field held while bit 11 was set. Changing bits 10:0 without this sequence, or holding bit 11 high, leaves the word that a read fetches unchanged.
- R3: A control write that sets read-start bit 25 while it was clear launches a read, provided that the same write has auto-read enable bit 24 at 1, power-down bit 27 at 0, and the controller is idle. The busy bit 26 reads 1 on the very next register read.
- R4: Busy stays high for exactly `LATENCY` cycles (default 8). The data register changes only in the cycle busy falls, and it holds the fetched word from then on.
- R5: A start request is ignored if auto-read enable is 0, if power-down is 1, or if a read is already in progress. An ignored request leaves busy low, or lets the running read end on its original schedule, and it leaves the data register untouched.
- R6: With `WORD_BYTES` = 1, the data register returns the byte at the committed address, zero-extended to 32 bits.
- R7: With `WORD_BYTES` = 4, the data register returns the bytes at addresses 4a to 4a+3 for word address a. Byte 4a lands in bits 7:0 (little-endian).
- R8: A word address at or beyond `ARRAY_BYTES`/`WORD_BYTES` returns 0 and issues no fuse byte request. The last in-range word is still fetched normally.
- R9: Auxiliary register bit 10 is stored, read back and driven on `fuse_enc_o`; its other bits read 0. Control bit 27 is driven on `fuse_pd_o`.
- R10: Writes to the data register are ignored. Control bits 26 and 14 are read-only: bit 26 always reflects busy and bit 14 always reads 0.
- R11: Each in-range read issues exactly `WORD_BYTES` fuse byte requests, all within the first `WORD_BYTES` cycles of busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access valid this cycle |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_off_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_off_i`, combinational |
| fuse_pd_o | output | 1 | Power-down control to the array |
| fuse_enc_o | output | 1 | Encryption-enable control to the array |
| fuse_rd_o | output | 1 | Fuse byte request |
| fuse_addr_o | output | clog2(ARRAY_BYTES) | Fuse byte address |
| fuse_data_i | input | 8 | Byte returned by the array for `fuse_addr_o` |

## Verification
The hardest case to reach is a second start request that arrives while a read is already running, after a new address has been committed. Telling an ignored restart apart from an accepted one requires sampling in the narrow window after the first read ends but before a restarted read would end. The stimulus drives one bus operation per cycle, counted from the launching write. It commits the new address and re-raises start within three cycles, then reads busy and data exactly one cycle after the original read should finish. The falling cycle of busy is pinned the same way, by reading the data register in the last busy cycle and again in the first idle one.

// File: rtl/efuse_rd_pkg.sv
package efuse_rd_pkg;
  localparam int unsigned OFF_W = 5;
  localparam logic [OFF_W-1:0] OFF_CTRL = 5'h04;
  localparam logic [OFF_W-1:0] OFF_DATA = 5'h08;
  localparam logic [OFF_W-1:0] OFF_AUX  = 5'h10;

  localparam int unsigned B_PD     = 27;
  localparam int unsigned B_RBUSY  = 26;
  localparam int unsigned B_RSTART = 25;
  localparam int unsigned B_REN    = 24;
  localparam int unsigned B_ASET   = 11;
  localparam int unsigned AUX_ENC  = 10;
  localparam int unsigned ADDR_W   = 11;

  // writable control bits: 27, 25:16, 13:0 (26 and 14 are status)
  localparam logic [31:0] CTRL_WMASK = 32'h0BFF_3FFF;
  localparam logic [31:0] CTRL_RST   = 32'h0800_0000;
endpackage

// File: rtl/efuse_rd_regs.sv
module efuse_rd_regs
  import efuse_rd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [31:0]       wdata_i,
  input  logic              busy_i,
  input  logic [31:0]       rdword_i,
  output logic [31:0]       rdata_o,
  output logic              launch_o,
  output logic [ADDR_W-1:0] caddr_o,
  output logic              pd_o,
  output logic              enc_o
);
  logic [31:0]       ctrl_q;
  logic              enc_q;
  logic [ADDR_W-1:0] caddr_q;
  logic              wr_ctrl, wr_aux;

  assign wr_ctrl = req_i & we_i & (off_i == OFF_CTRL);
  assign wr_aux  = req_i & we_i & (off_i == OFF_AUX);

  // start is edge-detected against the stored bit; gating uses the written word
  assign launch_o = wr_ctrl & wdata_i[B_RSTART] & ~ctrl_q[B_RSTART]
                  & wdata_i[B_REN] & ~wdata_i[B_PD] & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= CTRL_RST;
      enc_q   <= 1'b0;
      caddr_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= wdata_i & CTRL_WMASK;
        if (ctrl_q[B_ASET] && !wdata_i[B_ASET]) caddr_q <= ctrl_q[ADDR_W-1:0];
      end
      if (wr_aux) enc_q <= wdata_i[AUX_ENC];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (off_i)
      OFF_CTRL: begin
        rdata_o          = ctrl_q;
        rdata_o[B_RBUSY] = busy_i;
      end
      OFF_DATA: rdata_o = rdword_i;
      OFF_AUX:  rdata_o[AUX_ENC] = enc_q;
      default:  rdata_o = '0;
    endcase
  end

  assign caddr_o = caddr_q;
  assign pd_o    = ctrl_q[B_PD];
  assign enc_o   = enc_q;

  a_r3_busy_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(wr_ctrl && wdata_i[B_RSTART] && wdata_i[B_REN] && !wdata_i[B_PD]));

  a_r5_no_launch_powered_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !pd_o);
endmodule

// File: rtl/efuse_rd_fetch.sv
module efuse_rd_fetch
  import efuse_rd_pkg::*;
#(
  parameter int unsigned WORD_BYTES  = 4,
  parameter int unsigned LATENCY     = 8,
  parameter int unsigned ARRAY_BYTES = 512,
  parameter int unsigned FA_W        = $clog2(ARRAY_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [ADDR_W-1:0] waddr_i,
  output logic              busy_o,
  output logic [31:0]       data_o,
  output logic              fuse_rd_o,
  output logic [FA_W-1:0]   fuse_addr_o,
  input  logic [7:0]        fuse_data_i
);
  localparam int unsigned WORDS = ARRAY_BYTES / WORD_BYTES;
  localparam int unsigned CNT_W = $clog2(LATENCY + 1);
  localparam int unsigned WBITS = WORD_BYTES * 8;

  logic              busy_q, valid_q, take, last, in_range;
  logic [CNT_W-1:0]  cnt_q;
  logic [FA_W-1:0]   base_q;
  logic [WBITS-1:0]  buf_q, buf_nxt;
  logic [31:0]       data_q, word_ext;

  assign take     = busy_q & valid_q & (cnt_q < CNT_W'(WORD_BYTES));
  assign last     = (cnt_q == CNT_W'(LATENCY - 1));
  assign in_range = (32'(waddr_i) < 32'(WORDS));

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    assign buf_nxt[g*8 +: 8] = (take && cnt_q == CNT_W'(g)) ? fuse_data_i : buf_q[g*8 +: 8];
  end

  if (WBITS < 32) begin : g_narrow
    assign word_ext = {{(32-WBITS){1'b0}}, buf_nxt};
  end else begin : g_full
    assign word_ext = buf_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      cnt_q   <= '0;
      base_q  <= '0;
      buf_q   <= '0;
      data_q  <= '0;
    end else if (launch_i) begin
      busy_q  <= 1'b1;
      valid_q <= in_range;
      cnt_q   <= '0;
      base_q  <= FA_W'(32'(waddr_i) * WORD_BYTES);
      buf_q   <= '0;
    end else if (busy_q) begin
      buf_q <= buf_nxt;
      cnt_q <= cnt_q + 1'b1;
      if (last) begin
        busy_q <= 1'b0;
        data_q <= word_ext;
      end
    end
  end

  assign busy_o      = busy_q;
  assign data_o      = data_q;
  assign fuse_rd_o   = take;
  assign fuse_addr_o = base_q + FA_W'(cnt_q);

  a_r4_data_only_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(busy_q) |-> $stable(data_q));
endmodule

// File: rtl/efuse_rd_ctrl.sv
module efuse_rd_ctrl
  import efuse_rd_pkg::*;
#(
  parameter int unsigned WORD_BYTES  = 4,
  parameter int unsigned LATENCY     = 8,
  parameter int unsigned ARRAY_BYTES = 512
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           reg_req_i,
  input  logic                           reg_we_i,
  input  logic [4:0]                     reg_off_i,
  input  logic [31:0]                    reg_wdata_i,
  output logic [31:0]                    reg_rdata_o,
  output logic                           fuse_pd_o,
  output logic                           fuse_enc_o,
  output logic                           fuse_rd_o,
  output logic [$clog2(ARRAY_BYTES)-1:0] fuse_addr_o,
  input  logic [7:0]                     fuse_data_i
);
  localparam int unsigned FA_W  = $clog2(ARRAY_BYTES);
  localparam int unsigned AGE_W = $clog2(LATENCY + 1);

  logic              busy, launch;
  logic [ADDR_W-1:0] caddr;
  logic [31:0]       rdword;

  efuse_rd_regs i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (reg_req_i),
    .we_i     (reg_we_i),
    .off_i    (reg_off_i),
    .wdata_i  (reg_wdata_i),
    .busy_i   (busy),
    .rdword_i (rdword),
    .rdata_o  (reg_rdata_o),
    .launch_o (launch),
    .caddr_o  (caddr),
    .pd_o     (fuse_pd_o),
    .enc_o    (fuse_enc_o)
  );

  efuse_rd_fetch #(
    .WORD_BYTES  (WORD_BYTES),
    .LATENCY     (LATENCY),
    .ARRAY_BYTES (ARRAY_BYTES),
    .FA_W        (FA_W)
  ) i_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .waddr_i     (caddr),
    .busy_o      (busy),
    .data_o      (rdword),
    .fuse_rd_o   (fuse_rd_o),
    .fuse_addr_o (fuse_addr_o),
    .fuse_data_i (fuse_data_i)
  );

  // independent busy-age watch for the window checks
  logic [AGE_W-1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   age_q <= '0;
    else if (busy) age_q <= age_q + 1'b1;
    else           age_q <= '0;
  end

  a_r4_busy_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> age_q < AGE_W'(LATENCY));

  a_r4_busy_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> $past(age_q) == AGE_W'(LATENCY - 1));

  a_r11_rd_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_rd_o |-> busy && age_q < AGE_W'(WORD_BYTES));

  if (WORD_BYTES == 1) begin : g_byte_chk
    a_r6_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_off_i == OFF_DATA) |-> reg_rdata_o[31:8] == 24'h0);
  end
endmodule

// File: tb/test_efuse_rd_ctrl.sv
`timescale 1ns/1ps
module test_efuse_rd_ctrl;
  localparam int LAT = 8;
  localparam logic [4:0] CTRL = 5'h04, DATA = 5'h08, AUX = 5'h10;
  localparam logic [31:0] EN = 32'h0100_0000, START = 32'h0200_0000,
                          PD = 32'h0800_0000, SETB = 32'h0000_0800, BUSY = 32'h0400_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_w = 0, req_b = 0, we = 0;
  logic [4:0]  off = '0;
  logic [31:0] wdata = '0, rdata_w, rdata_b;
  logic        pd_w, enc_w, frd_w, pd_b, enc_b, frd_b;
  logic [8:0]  fa_w, fa_b;
  logic [7:0]  fd_w, fd_b;

  function automatic logic [7:0] rom(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction
  function automatic logic [31:0] w4(input int a);
    return {rom(4*a+3), rom(4*a+2), rom(4*a+1), rom(4*a)};
  endfunction

  assign fd_w = rom(int'(fa_w));
  assign fd_b = rom(int'(fa_b));

  efuse_rd_ctrl #(.WORD_BYTES(4), .LATENCY(LAT)) i_efuse_rd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req_w), .reg_we_i(we), .reg_off_i(off),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata_w), .fuse_pd_o(pd_w), .fuse_enc_o(enc_w),
    .fuse_rd_o(frd_w), .fuse_addr_o(fa_w), .fuse_data_i(fd_w));

  efuse_rd_ctrl #(.WORD_BYTES(1), .LATENCY(LAT)) i_efuse_rd_ctrl_byte (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req_b), .reg_we_i(we), .reg_off_i(off),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata_b), .fuse_pd_o(pd_b), .fuse_enc_o(enc_b),
    .fuse_rd_o(frd_b), .fuse_addr_o(fa_b), .fuse_data_i(fd_b));

  int checks = 0, fails = 0, frd_cnt = 0;
  bit done = 0;

  typedef struct { int sel; logic [31:0] exp; string tag; } exp_t;
  exp_t sb[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n && frd_w) frd_cnt++;

  // monitor: pops one expected item per read cycle
  always @(negedge clk) begin
    if ((req_w || req_b) && !we) begin
      if (sb.size() == 0) chk("SB", 32'h0, 32'h1);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, (e.sel != 0) ? rdata_b : rdata_w, e.exp);
      end
    end
  end

  task automatic op(input int s, input logic w, input logic [4:0] o, input logic [31:0] d);
    @(posedge clk); #2;
    req_w = (s == 0); req_b = (s == 1); we = w; off = o; wdata = d;
  endtask
  task automatic idle();
    @(posedge clk); #2;
    req_w = 0; req_b = 0; we = 0;
  endtask
  task automatic wr(input int s, input logic [4:0] o, input logic [31:0] d);
    op(s, 1'b1, o, d);
  endtask
  task automatic rd(input int s, input logic [4:0] o, input logic [31:0] e, input string tag);
    exp_t x;
    x.sel = s; x.exp = e; x.tag = tag;
    sb.push_back(x);
    op(s, 1'b0, o, 32'h0);
  endtask
  task automatic commit(input int s, input int a);
    wr(s, CTRL, EN | SETB | 32'(a));
    wr(s, CTRL, EN | 32'(a));
  endtask
  task automatic fetch(input int s, input int a, input logic [31:0] extra);
    wr(s, CTRL, EN | START | extra | 32'(a));
    wr(s, CTRL, EN | extra | 32'(a));
    repeat (LAT) idle();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(0, CTRL, PD, "R1 ctrl");
    rd(0, DATA, 0, "R1 data");
    rd(0, AUX, 0, "R1 aux");
    idle();
    chk("R1 pd pin", 32'(pd_w), 1);

    // R9 aux / pins
    wr(0, AUX, 32'hFFFF_FFFF);
    idle();
    chk("R9 enc pin", 32'(enc_w), 1);
    rd(0, AUX, 32'h0000_0400, "R9 aux readback");
    wr(0, CTRL, EN);
    idle();
    chk("R9 pd pin clear", 32'(pd_w), 0);

    // R10 read-only bits and data register
    wr(0, CTRL, EN | BUSY | 32'h0000_4000);
    rd(0, CTRL, EN, "R10 status bits");
    wr(0, DATA, 32'hDEAD_BEEF);
    rd(0, DATA, 0, "R10 data write ignored");

    // R7 little-endian word
    commit(0, 5);
    fetch(0, 5, 0);
    rd(0, DATA, w4(5), "R7 word 5");

    // R3 / R4 busy visibility and length
    commit(0, 6);
    wr(0, CTRL, EN | START | 6);
    rd(0, CTRL, EN | START | BUSY | 6, "R3 busy on first read");
    for (int k = 2; k <= LAT; k++) rd(0, CTRL, EN | START | BUSY | 6, "R4 busy held");
    rd(0, CTRL, EN | START | 6, "R4 busy clear");
    rd(0, DATA, w4(6), "R4 data word 6");
    wr(0, CTRL, EN | 6);

    // R4 data changes exactly when busy falls
    commit(0, 7);
    wr(0, CTRL, EN | START | 7);
    wr(0, CTRL, EN | 7);
    repeat (LAT - 2) idle();
    rd(0, DATA, w4(6), "R4 data old in last busy cycle");
    rd(0, DATA, w4(7), "R4 data new after fall");
    rd(0, CTRL, EN | 7, "R4 idle after fall");

    // R2 address commit
    commit(0, 3);
    fetch(0, 3, 0);
    rd(0, DATA, w4(3), "R2 word 3");
    wr(0, CTRL, EN | 9);
    fetch(0, 9, 0);
    rd(0, DATA, w4(3), "R2 uncommitted addr");
    wr(0, CTRL, EN | SETB | 10);
    fetch(0, 10, SETB);
    rd(0, DATA, w4(3), "R2 set held high");
    wr(0, CTRL, EN | 10);
    fetch(0, 10, 0);
    rd(0, DATA, w4(10), "R2 committed 10");

    // R5 ignored starts
    commit(0, 12);
    wr(0, CTRL, 12);
    wr(0, CTRL, START | 12);
    rd(0, CTRL, START | 12, "R5 enable low no busy");
    wr(0, CTRL, 12);
    repeat (LAT) idle();
    rd(0, DATA, w4(10), "R5 enable low no data");
    wr(0, CTRL, PD | EN | START | 12);
    rd(0, CTRL, PD | EN | START | 12, "R5 powered down no busy");
    wr(0, CTRL, PD | EN | 12);
    repeat (LAT) idle();
    rd(0, DATA, w4(10), "R5 powered down no data");
    // restart during busy
    wr(0, CTRL, EN | START | 12);
    wr(0, CTRL, EN | SETB | 14);
    wr(0, CTRL, EN | 14);
    wr(0, CTRL, EN | START | 14);
    repeat (LAT - 3) idle();
    rd(0, CTRL, EN | START | 14, "R5 restart ignored busy");
    rd(0, DATA, w4(12), "R5 restart ignored data");
    wr(0, CTRL, EN | 14);

    // R8 / R11 range and strobes
    commit(0, 128);
    base = frd_cnt;
    fetch(0, 128, 0);
    rd(0, DATA, 0, "R8 out of range word");
    chk("R8 no strobes out of range", 32'(frd_cnt - base), 0);
    commit(0, 127);
    base = frd_cnt;
    fetch(0, 127, 0);
    rd(0, DATA, w4(127), "R8 last word");
    chk("R11 strobe count", 32'(frd_cnt - base), 4);

    // R6 byte mode
    commit(1, 300);
    fetch(1, 300, 0);
    rd(1, DATA, {24'h0, rom(300)}, "R6 byte 300");
    commit(1, 511);
    fetch(1, 511, 0);
    rd(1, DATA, {24'h0, rom(511)}, "R6 byte 511");
    commit(1, 512);
    fetch(1, 512, 0);
    rd(1, DATA, 0, "R8 byte out of range");

    idle();
    repeat (3) idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule